// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers a set of device interrupt request lines and folds them onto one interrupt output toward the processor. Each rising edge on a request line is remembered in a pending register, so a short pulse from a device is not lost. While any pending line that is not masked exists, the controller raises its interrupt output and keeps it raised until the processor acknowledges.

The processor acknowledges by raising an acknowledge strobe when it is ready to take the interrupt. In the first cycle of that strobe the controller picks the pending, unmasked line of highest priority, clears only that line's pending bit, and places an interrupt number on its data output with the output enable set. The number is a configurable base plus the line index. The processor then uses that number to look up a handler. After the strobe ends, the interrupt output comes back at once if other unmasked requests are still waiting.

A mask register, loaded through a write strobe, can block single lines. A blocked line keeps its pending bit but cannot raise the interrupt output and is never picked. An acknowledge that finds nothing to serve returns a fixed spurious number and changes no state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset int_o is 0, data_oe_o is 0, data_o is 0, no line is pending and every mask bit is 0 (all lines enabled).
- R2: A 0-to-1 change on irq_i[k], sampled at a clock edge, sets line k pending at that edge; int_o rises at the following edge. A line held high sets pending only once per rising edge.
- R3: A pending bit stays set until its line is granted by an acknowledge; one acknowledge clears exactly the granted line and leaves the others pending.
- R4: The granted line is the lowest-numbered line that is both pending and unmasked (line 0 highest priority).
- R5: The data value is (vec_base_i + line index) modulo 2^VEC_W. At each edge where inta_i is sampled 1, data_oe_o becomes 1 and data_o takes that value; at each edge where inta_i is sampled 0, data_oe_o becomes 0.
- R6: Whenever data_oe_o is 0, data_o is all zeros.
- R7: int_o is 0 in every cycle following an edge where inta_i was sampled 1; at the first edge with inta_i sampled 0 it becomes 1 if any unmasked line is still pending.
- R8: Mask bit k = 1 (written from mask_d_i when mask_we_i is 1) blocks line k: it stays pending, does not raise int_o and is not granted; clearing the mask bit lets it raise int_o again.
- R9: An acknowledge with no unmasked pending line returns vec_base_i + N_LINES and clears nothing.
- R10: The line is chosen in the first cycle of inta_i; requests arriving while inta_i stays high do not change the number on data_o for that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N_LINES | Device request lines, rising edge latched |
| mask_we_i | input | 1 | Load strobe for the mask register |
| mask_d_i | input | N_LINES | New mask value, 1 blocks a line |
| vec_base_i | input | VEC_W | Base added to the granted line index |
| inta_i | input | 1 | Processor acknowledge strobe |
| int_o | output | 1 | Interrupt request to the processor |
| data_o | output | VEC_W | Interrupt number, zero when not enabled |
| data_oe_o | output | 1 | Data output enable, follows inta_i one cycle later |

## Verification
On every cycle the checker confirms that the data bus is quiet without its enable, that the enable tracks the acknowledge strobe one edge later, that the interrupt output stays low after an acknowledge cycle, that pending bits vanish only on an acknowledge and at most one at a time, and that any driven number lies within the base-plus-index range. Which line wins under a given mix of requests and masks, the exact number returned, the spurious number, the modulo wrap of the base and the behaviour of a held level or of a request that lands mid-acknowledge are shown only by the bench's scenarios.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Width of a line index able to also encode "none" (value N).
  function automatic int idx_width(input int n_lines);
    return $clog2(n_lines + 1);
  endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] pend_o
);

  logic [N_LINES-1:0] req_q;
  logic [N_LINES-1:0] rise;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign rise[g] = req_i[g] & ~req_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[g]  <= 1'b0;
        pend_o[g] <= 1'b0;
      end else begin
        req_q[g] <= req_i[g];
        // a fresh edge wins over a clear in the same cycle
        pend_o[g] <= (pend_o[g] & ~clr_i[g]) | rise[g];
      end
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_LINES = 8,
  parameter int IW      = 4
) (
  input  logic [N_LINES-1:0] elig_i,
  output logic [IW-1:0]      idx_o,
  output logic               any_o
);

  // chain from lowest priority upward; line 0 is examined last and wins
  logic [IW-1:0] chain [N_LINES+1];

  assign chain[N_LINES] = IW'(N_LINES);

  for (genvar g = N_LINES - 1; g >= 0; g--) begin : g_stage
    assign chain[g] = elig_i[g] ? IW'(g) : chain[g+1];
  end

  assign idx_o = chain[0];
  assign any_o = |elig_i;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               mask_we_i,
  input  logic [N_LINES-1:0] mask_d_i,
  input  logic [VEC_W-1:0]   vec_base_i,
  input  logic               inta_i,
  output logic               int_o,
  output logic [VEC_W-1:0]   data_o,
  output logic               data_oe_o
);

  localparam int IW = irq_vec_pkg::idx_width(N_LINES);

  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] elig;
  logic [N_LINES-1:0] clr;
  logic               inta_q;
  logic               ack_start;
  logic               win_any;
  logic [IW-1:0]      win_idx;
  logic [IW-1:0]      held_idx;
  logic [IW-1:0]      cur_idx;

  irq_edge_latch #(.N_LINES(N_LINES)) latch_i (
    .clk    (clk),
    .rst    (rst),
    .req_i  (irq_i),
    .clr_i  (clr),
    .pend_o (pend_q)
  );

  assign elig = pend_q & ~mask_q;

  irq_prio_pick #(.N_LINES(N_LINES), .IW(IW)) pick_i (
    .elig_i (elig),
    .idx_o  (win_idx),
    .any_o  (win_any)
  );

  assign ack_start = inta_i & ~inta_q;
  assign cur_idx   = ack_start ? win_idx : held_idx;

  for (genvar g = 0; g < N_LINES; g++) begin : g_clr
    assign clr[g] = ack_start & win_any & (win_idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      inta_q    <= 1'b0;
      held_idx  <= IW'(N_LINES);
      int_o     <= 1'b0;
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_d_i;
      inta_q <= inta_i;
      if (ack_start) held_idx <= win_idx;
      int_o     <= win_any & ~inta_i;
      data_oe_o <= inta_i;
      data_o    <= inta_i ? VEC_W'(vec_base_i + VEC_W'(cur_idx)) : '0;
    end
  end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               inta_i,
  input logic               int_o,
  input logic [VEC_W-1:0]   data_o,
  input logic               data_oe_o,
  input logic [VEC_W-1:0]   vec_base_i,
  input logic [N_LINES-1:0] pend_q,
  input logic               ack_start
);

  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !data_oe_o |-> data_o == '0);

  a_r5_oe_rise: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inta_i)) |-> data_oe_o);

  a_r5_oe_fall: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inta_i)) |-> !data_oe_o);

  a_r5_vec_range: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> VEC_W'(data_o - vec_base_i) <= VEC_W'(N_LINES));

  a_r7_int_low_ack: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inta_i)) |-> !int_o);

  a_r3_clear_on_ack: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|($past(pend_q) & ~pend_q))) |-> $past(ack_start));

  a_r3_one_clear: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones($past(pend_q) & ~pend_q) <= 1);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .inta_i     (inta_i),
  .int_o      (int_o),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .vec_base_i (vec_base_i),
  .pend_q     (pend_q),
  .ack_start  (ack_start)
);

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;

  localparam int N = 8;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] irq;
  logic         mask_we;
  logic [N-1:0] mask_d;
  logic [W-1:0] base;
  logic         inta;
  logic         int_o;
  logic [W-1:0] data;
  logic         oe;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.N_LINES(N), .VEC_W(W)) dut_i (
    .clk(clk), .rst(rst), .irq_i(irq), .mask_we_i(mask_we), .mask_d_i(mask_d),
    .vec_base_i(base), .inta_i(inta), .int_o(int_o), .data_o(data), .data_oe_o(oe)
  );

  // {mask, pulse pattern, int expected, number expected, int after ack}
  localparam logic [25:0] TBL [8] = '{
    {8'h00, 8'h01, 1'b1, 8'h20, 1'b0},
    {8'h00, 8'h80, 1'b1, 8'h27, 1'b0},
    {8'h00, 8'h28, 1'b1, 8'h23, 1'b1},
    {8'h00, 8'hF0, 1'b1, 8'h24, 1'b1},
    {8'h0F, 8'h1F, 1'b1, 8'h24, 1'b0},
    {8'hFF, 8'hFF, 1'b0, 8'h28, 1'b0},
    {8'hFE, 8'h03, 1'b1, 8'h20, 1'b0},
    {8'h00, 8'hC0, 1'b1, 8'h26, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [W-1:0] b);
    rst = 1'b1; irq = '0; inta = 1'b0; mask_we = 1'b0; mask_d = '0; base = b;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  task automatic write_mask(input logic [N-1:0] m);
    mask_we = 1'b1; mask_d = m;
    step(1);
    mask_we = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    irq = p;
    step(1);
    irq = '0;
    step(1);
  endtask

  // two-cycle acknowledge, checks during and after
  task automatic ack(input string req, input int exp_vec, input int exp_after);
    inta = 1'b1;
    step(1);
    check({req, " oe in ack"}, oe, 1);
    check({req, " number"}, data, exp_vec);
    check("R7 int low in ack", int_o, 0);
    step(1);
    check({req, " number held"}, data, exp_vec);
    inta = 1'b0;
    step(1);
    check("R5 oe drops", oe, 0);
    check("R6 bus zero", data, 0);
    check("R7 int after ack", int_o, exp_after);
  endtask

  initial begin
    // R1: reset state
    do_reset(8'h20);
    check("R1 int_o", int_o, 0);
    check("R1 oe", oe, 0);
    check("R1 data", data, 0);
    pulse(8'h10);
    check("R1 mask clear at reset", int_o, 1);

    // table walk: R4 priority, R8 masks, R9 spurious
    for (int i = 0; i < 8; i++) begin
      do_reset(8'h20);
      write_mask(TBL[i][25:18]);
      pulse(TBL[i][17:10]);
      check("R4 R8 int_o", int_o, int'(TBL[i][9]));
      ack("R4 R5 R9", int'(TBL[i][8:1]), int'(TBL[i][0]));
    end

    // R2: held level latches once
    do_reset(8'h20);
    irq = 8'h04;
    step(2);
    check("R2 int rises", int_o, 1);
    ack("R2", 8'h22, 0);
    step(2);
    check("R2 held level no relatch", int_o, 0);
    irq = '0;

    // R3: two pending served in turn
    do_reset(8'h20);
    pulse(8'h0A);
    ack("R3 first", 8'h21, 1);
    ack("R3 second", 8'h23, 0);

    // R10: request arriving mid-acknowledge
    do_reset(8'h20);
    pulse(8'h08);
    inta = 1'b1;
    step(1);
    check("R10 number", data, 8'h23);
    irq = 8'h01;
    step(1);
    irq = '0;
    check("R10 number unchanged", data, 8'h23);
    inta = 1'b0;
    step(1);
    check("R10 oe drops", oe, 0);
    check("R7 int reasserts", int_o, 1);
    ack("R10 late line", 8'h20, 0);

    // R8: masked line stays pending, unmask releases it
    do_reset(8'h20);
    write_mask(8'h01);
    pulse(8'h01);
    check("R8 masked no int", int_o, 0);
    pulse(8'h04);
    check("R8 other line int", int_o, 1);
    ack("R8 skip masked", 8'h22, 0);
    write_mask(8'h00);
    step(1);
    check("R8 unmask raises int", int_o, 1);
    ack("R8 now served", 8'h20, 0);

    // R9: spurious acknowledge, then a real one still works
    do_reset(8'h20);
    ack("R9 spurious", 8'h28, 0);
    pulse(8'h02);
    ack("R9 after spurious", 8'h21, 0);

    // R5: base wraps modulo 2^W
    do_reset(8'hFC);
    pulse(8'h20);
    ack("R5 wrap", 8'h01, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule